// File: doc/BRIEF.md
# Walsh-Hadamard Bit-Stream Spectral Unit

This unit turns a short binary bit-stream into its Walsh-Hadamard spectrum. A typical stream is the series of values that one circuit input takes over a run of test vectors. Each bit is first mapped to a signed level: logic 1 becomes +1 and logic 0 becomes -1. The unit then correlates the stream with every row of a Sylvester-ordered Hadamard matrix, and it reports the index of the strongest coefficient.

The same transform also works in the other direction and regenerates a stream. Any coefficient whose magnitude falls below a threshold is cleared. The surviving spectrum goes back through the transform, and the sign of each result becomes a new bit. A zero threshold gives back the original stream. A larger threshold removes the weak spectral terms and so yields a noisy version of the stream with the same spectral shape. A caller presents the stream and the threshold, pulses start, and collects the results when done pulses.

Top module: `wht_spectral_unit`

## Requirements
- R1: While reset is applied and after it ends, done_o is 0, every coefficient reads 0, regen_o is 0 and peak_o is 0.
- R2: Coefficient k, carried in coef_o[k*CW +: CW] as a two's-complement value of CW = ORDER+2 bits, equals the sum over t of s_t * h(k,t). Bit t of stream_i is sample t. s_t is +1 when that bit is 1 and -1 when it is 0. h(k,t) is -1 when popcount(k AND t) is odd and +1 otherwise.
- R3: A start_i sampled high on a clock edge while the unit is idle is accepted at that edge, and coef_o shows the new spectrum right after it. done_o goes high for exactly one cycle after the following edge. At that point regen_o and peak_o are valid, and all three outputs hold until the next accepted start.
- R4: A start_i seen on the edge right after an accepted start is ignored: no extra done pulse is produced and the first stream's results are kept.
- R5: For regeneration, any coefficient with |c| < thresh_i (an unsigned CW-bit value) is set to zero. The remaining spectrum is multiplied by the same Hadamard matrix, and bit t of regen_o is 1 when result t is positive and 0 when it is negative.
- R6: An inverse result of exactly zero gives a regenerated bit of 1. In particular, a threshold above every coefficient magnitude makes regen_o all ones.
- R7: With thresh_i equal to 0, regen_o equals the accepted stream.
- R8: peak_o is the index of the unthresholded coefficient with the largest magnitude. When several coefficients share that magnitude, the lowest index wins.
- R9: Only the thresh_i and stream_i values present at the accepted start edge matter. Changes to either input afterwards do not alter that request's results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe |
| stream_i | input | LEN | Bit-stream, bit t is sample t |
| thresh_i | input | CW | Unsigned magnitude threshold for regeneration |
| coef_o | output | LEN*CW | Packed signed spectral coefficients |
| regen_o | output | LEN | Regenerated bit-stream |
| peak_o | output | ORDER | Index of the prominent coefficient |
| done_o | output | 1 | One-cycle pulse when all results are valid |

## Verification
The bench targets streams that are all ones or all zeros. These put the entire energy into coefficient 0 and reach the edge of the coefficient width, so a design with one bit too few would wrap that value to the wrong sign. Spectra with several coefficients of equal magnitude test the lowest-index tie rule; a design using greater-or-equal in its comparison would report the last of them instead. A threshold above every magnitude tests the zero-result rule; a design that read the sign bit the wrong way would return all zeros. A second start in the busy cycle, and a threshold that changes after acceptance, expose a design that restarts on the second strobe or that reads its threshold live.

// File: rtl/wht_pkg.sv
package wht_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_INV  = 2'd1,
    PH_DONE = 2'd2
  } phase_e;

  // magnitude of a signed integer
  function automatic int abs_val(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // sign decision: zero and positive give logic 1
  function automatic logic sign_bit(input int v);
    return (v >= 0);
  endfunction

  // signed level for a stream bit
  function automatic int level_of(input logic b);
    return b ? 1 : -1;
  endfunction

endpackage

// File: rtl/wht_butterfly.sv
module wht_butterfly #(
  parameter int ORDER = 3,
  parameter int W     = 5
) (
  input  logic [(1<<ORDER)*W-1:0] vec_i,
  output logic [(1<<ORDER)*W-1:0] vec_o
);
  localparam int LEN = 1 << ORDER;

  logic signed [W-1:0] st [ORDER+1][LEN];

  for (genvar t = 0; t < LEN; t++) begin : g_io
    assign st[0][t] = vec_i[t*W +: W];
    assign vec_o[t*W +: W] = st[ORDER][t];
  end

  // stage s pairs index i with i + 2^s where bit s of i is clear
  for (genvar s = 0; s < ORDER; s++) begin : g_stage
    for (genvar i = 0; i < LEN; i++) begin : g_pair
      if (((i >> s) & 1) == 0) begin : g_top
        localparam int J = i + (1 << s);
        assign st[s+1][i] = st[s][i] + st[s][J];
        assign st[s+1][J] = st[s][i] - st[s][J];
      end
    end
  end

endmodule

// File: rtl/wht_sieve.sv
module wht_sieve
  import wht_pkg::*;
#(
  parameter int ORDER = 3,
  parameter int CW    = ORDER + 2
) (
  input  logic [(1<<ORDER)*CW-1:0] coef_i,
  input  logic [CW-1:0]            thresh_i,
  output logic [(1<<ORDER)*CW-1:0] kept_o,
  output logic [ORDER-1:0]         peak_o
);
  localparam int LEN = 1 << ORDER;

  always_comb begin
    int best;
    int idx;
    int c;
    int m;
    best   = -1;
    idx    = 0;
    kept_o = '0;
    for (int k = 0; k < LEN; k++) begin
      c = int'($signed(coef_i[k*CW +: CW]));
      m = abs_val(c);
      if (m >= int'({1'b0, thresh_i}))
        kept_o[k*CW +: CW] = coef_i[k*CW +: CW];
      if (m > best) begin
        best = m;
        idx  = k;
      end
    end
    peak_o = idx[ORDER-1:0];
  end

endmodule

// File: rtl/wht_spectral_unit.sv
module wht_spectral_unit
  import wht_pkg::*;
#(
  parameter int ORDER = 3,
  parameter int LEN   = 1 << ORDER,
  parameter int CW    = ORDER + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [LEN-1:0]      stream_i,
  input  logic [CW-1:0]       thresh_i,
  output logic [LEN*CW-1:0]   coef_o,
  output logic [LEN-1:0]      regen_o,
  output logic [ORDER-1:0]    peak_o,
  output logic                done_o
);
  localparam int IW = 2*ORDER + 2;

  phase_e             phase_q;
  logic [LEN*CW-1:0]  coef_q;
  logic [CW-1:0]      thr_q;
  logic [LEN-1:0]     regen_q;
  logic [ORDER-1:0]   peak_q;

  // named internal events
  logic busy;
  logic accept;
  assign busy   = (phase_q == PH_INV);
  assign accept = start_i && !busy;

  // stream to signed levels
  logic [LEN*CW-1:0] levels;
  for (genvar t = 0; t < LEN; t++) begin : g_lvl
    assign levels[t*CW +: CW] = stream_i[t] ? CW'(1) : {CW{1'b1}};
  end

  logic [LEN*CW-1:0] fwd_coef;
  wht_butterfly #(.ORDER(ORDER), .W(CW)) u_fwd (
    .vec_i (levels),
    .vec_o (fwd_coef)
  );

  logic [LEN*CW-1:0] kept;
  logic [ORDER-1:0]  peak_c;
  wht_sieve #(.ORDER(ORDER), .CW(CW)) u_sieve (
    .coef_i   (coef_q),
    .thresh_i (thr_q),
    .kept_o   (kept),
    .peak_o   (peak_c)
  );

  logic [LEN*IW-1:0] kept_ext;
  for (genvar k = 0; k < LEN; k++) begin : g_ext
    assign kept_ext[k*IW +: IW] = {{(IW-CW){kept[k*CW+CW-1]}}, kept[k*CW +: CW]};
  end

  logic [LEN*IW-1:0] inv_vec;
  wht_butterfly #(.ORDER(ORDER), .W(IW)) u_inv (
    .vec_i (kept_ext),
    .vec_o (inv_vec)
  );

  logic [LEN-1:0] regen_c;
  for (genvar t = 0; t < LEN; t++) begin : g_sign
    assign regen_c[t] = ~inv_vec[t*IW + IW - 1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      coef_q  <= '0;
      thr_q   <= '0;
      regen_q <= '0;
      peak_q  <= '0;
    end else begin
      if (accept) begin
        coef_q <= fwd_coef;
        thr_q  <= thresh_i;
      end
      case (phase_q)
        PH_INV: begin
          regen_q <= regen_c;
          peak_q  <= peak_c;
          phase_q <= PH_DONE;
        end
        default: phase_q <= accept ? PH_INV : PH_IDLE;
      endcase
    end
  end

  assign coef_o  = coef_q;
  assign regen_o = regen_q;
  assign peak_o  = peak_q;
  assign done_o  = (phase_q == PH_DONE);

  // assertions
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_accept_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ##2 done_o);

  p_busy_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(coef_o));

  p_dc_term_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (int'($signed(coef_o[CW-1:0])) == 2*$countones($past(stream_i)) - LEN));

  p_zero_thr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(accept, 2) && ($past(thresh_i, 2) == '0))
      |-> (regen_o == $past(stream_i, 2)));

endmodule

// File: tb/sim_wht_spectral_unit.sv
module sim_wht_spectral_unit;
  localparam int ORDER = 3;
  localparam int LEN   = 1 << ORDER;
  localparam int CW    = ORDER + 2;

  typedef struct packed {
    logic [LEN*CW-1:0] coef;
    logic [LEN-1:0]    regen;
    logic [ORDER-1:0]  peak;
  } item_t;

  logic              clk = 0;
  logic              rst_n = 0;
  logic              start_i = 0;
  logic [LEN-1:0]    stream_i = '0;
  logic [CW-1:0]     thresh_i = '0;
  logic [LEN*CW-1:0] coef_o;
  logic [LEN-1:0]    regen_o;
  logic [ORDER-1:0]  peak_o;
  logic              done_o;

  wht_spectral_unit #(.ORDER(ORDER)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stream_i(stream_i),
    .thresh_i(thresh_i), .coef_o(coef_o), .regen_o(regen_o),
    .peak_o(peak_o), .done_o(done_o)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int pushes = 0;
  int dones  = 0;
  bit finished = 0;
  item_t q[$];
  string tagq[$];

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int hsign(input int k, input int t);
    return ($countones(k & t) % 2) ? -1 : 1;
  endfunction

  function automatic item_t model(input logic [LEN-1:0] s, input int thr);
    item_t it;
    int c [LEN];
    int best;
    it = '0;
    best = -1;
    for (int k = 0; k < LEN; k++) begin
      c[k] = 0;
      for (int t = 0; t < LEN; t++) c[k] += (s[t] ? 1 : -1) * hsign(k, t);
      it.coef[k*CW +: CW] = c[k][CW-1:0];
      if ((c[k] < 0 ? -c[k] : c[k]) > best) begin
        best = (c[k] < 0 ? -c[k] : c[k]);
        it.peak = k[ORDER-1:0];
      end
    end
    for (int t = 0; t < LEN; t++) begin
      int acc;
      acc = 0;
      for (int k = 0; k < LEN; k++)
        if ((c[k] < 0 ? -c[k] : c[k]) >= thr) acc += c[k] * hsign(k, t);
      it.regen[t] = (acc >= 0);
    end
    return it;
  endfunction

  task automatic run(input logic [LEN-1:0] s, input logic [CW-1:0] thr,
                     input bit dbl, input bit late, input string tag);
    @(negedge clk);
    stream_i = s;
    thresh_i = thr;
    start_i  = 1;
    q.push_back(model(s, int'(thr)));
    tagq.push_back(tag);
    pushes++;
    @(negedge clk);
    start_i = dbl;
    if (dbl) stream_i = ~s;
    if (late) begin
      thresh_i = thr ^ 5'h1F;
      stream_i = ~s;
    end
    @(negedge clk);
    start_i = 0;
    repeat (2) @(negedge clk);
  endtask

  // monitor / scoreboard
  bit prev_done = 0;
  logic [LEN*CW-1:0] held_coef;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (prev_done) begin
        check(!done_o, "R3 done pulse width", 64'(done_o), 64'd0);
        check(coef_o == held_coef, "R3 coef held", 64'(coef_o), 64'(held_coef));
      end
      if (done_o) begin
        dones++;
        if (q.size() == 0) begin
          check(0, "R4 unexpected done", 64'd1, 64'd0);
        end else begin
          item_t e;
          string tg;
          e  = q.pop_front();
          tg = tagq.pop_front();
          check(coef_o == e.coef, {"R2 coef ", tg}, 64'(coef_o), 64'(e.coef));
          check(regen_o == e.regen, {"R5 regen ", tg}, 64'(regen_o), 64'(e.regen));
          check(peak_o == e.peak, {"R8 peak ", tg}, 64'(peak_o), 64'(e.peak));
        end
        held_coef = coef_o;
      end
      prev_done = done_o;
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] lf;
    repeat (3) @(negedge clk);
    check(done_o == 0, "R1 done in reset", 64'(done_o), 64'd0);
    rst_n = 1;
    @(negedge clk);
    check(done_o == 0, "R1 done", 64'(done_o), 64'd0);
    check(coef_o == '0, "R1 coef", 64'(coef_o), 64'd0);
    check(regen_o == '0, "R1 regen", 64'(regen_o), 64'd0);
    check(peak_o == '0, "R1 peak", 64'(peak_o), 64'd0);

    // R7 zero threshold gives the stream back; R2 extremes
    run(8'hA5, 5'd0, 0, 0, "R7 a5");
    check(regen_o == 8'hA5, "R7 copy a5", 64'(regen_o), 64'hA5);
    run(8'hFF, 5'd0, 0, 0, "R7 all ones");
    check(coef_o[CW-1:0] == 5'd8, "R2 dc ones", 64'(coef_o[CW-1:0]), 64'd8);
    run(8'h00, 5'd0, 0, 0, "R7 all zeros");
    check(coef_o[CW-1:0] == 5'h18, "R2 dc zeros", 64'(coef_o[CW-1:0]), 64'h18);
    check(regen_o == 8'h00, "R7 copy zeros", 64'(regen_o), 64'h00);
    run(8'h01, 5'd0, 0, 0, "R7 single");

    // R8 ties between equal magnitudes
    run(8'h03, 5'd0, 0, 0, "R8 tie four");
    check(peak_o == 3'd0, "R8 tie lowest", 64'(peak_o), 64'd0);
    run(8'hE8, 5'd0, 0, 0, "R8 tie majority");
    check(peak_o == 3'd1, "R8 tie majority lowest", 64'(peak_o), 64'd1);

    // R5 partial threshold: only coefficient 4 survives
    run(8'h07, 5'd3, 0, 0, "R5 thr3");
    check(regen_o == 8'h0F, "R5 shaped", 64'(regen_o), 64'h0F);

    // R6 everything removed -> all zero sums -> all ones
    run(8'h5C, 5'd9, 0, 0, "R6 thr9");
    check(regen_o == 8'hFF, "R6 zero to one", 64'(regen_o), 64'hFF);

    // R4 second start during busy cycle
    run(8'h96, 5'd2, 1, 0, "R4 double");
    repeat (2) @(negedge clk);
    check(dones == pushes, "R4 done count", 64'(dones), 64'(pushes));

    // R9 inputs change after acceptance
    run(8'h3A, 5'd3, 0, 1, "R9 late");

    // mixed patterns
    lf = 8'hB7;
    for (int n = 0; n < 40; n++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      run(lf, CW'(n % 10), 0, 0, "R5 sweep");
    end

    repeat (4) @(negedge clk);
    check(q.size() == 0, "R3 all results seen", 64'(q.size()), 64'd0);
    check(dones == pushes, "R4 total dones", 64'(dones), 64'(pushes));
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule